// File: doc/BRIEF.md
# Multi-Size LRU Stack Tag Store

This block is the tag side of a single-set, fully associative cache that uses true least-recently-used replacement. Each entry holds the block-aligned part of an address, so the set index is always zero and the number of ways equals the number of entries. A recency stack places every entry at a depth from 0 (most recent) to N-1 (least recent). A hitting access moves its entry to depth 0. A separate probe port looks up an address and leaves the order unchanged.

The stack depth of a hit also gives the result for smaller caches. A cache of C entries that uses the same replacement rule holds exactly the lines at depth below C. Each access therefore reports, in the same cycle, a residency mask with one bit per power-of-two size below full capacity. The block also keeps hit and miss counters for each size.

All operations complete in one cycle and the block never stalls. The edge is therefore a set of plain strobes with no ready signals, and the issuer needs no back-pressure rules. Lookup results on `acc_*` and `prb_*` are combinational from the current state.

Top module: `mlru_tag_store`

## Requirements
- R1: The stored tag is the address with its low log2(BLK_BYTES) offset bits cleared. Two addresses in the same block hit the same entry. `vic_addr` always has zero offset bits and equals the victim's block address.
- R2: `acc_hit` and `acc_way` report, in the same cycle, whether a valid entry matches `acc_addr` and which way it is. Only valid entries can match.
- R3: An access that is taken and hits moves its entry to depth 0. Every entry that was shallower moves one position deeper, and all other entries keep their depth.
- R4: `prb_hit` and `prb_way` report a match for `prb_addr` in the same way. Probing never changes recency or validity.
- R5: Bit i of `acc_mask` is set exactly when the access hits at a depth below BASE_ENTRIES·2^i. A miss gives an all-zero mask.
- R6: Every taken access increments `cnt_access`. For level i, which has capacity BASE_ENTRIES·2^i, the field at bits [i·CNT_W +: CNT_W] of `cnt_hit` increments when the hit depth is below that capacity. Otherwise the same field of `cnt_miss` increments. The top level is the full capacity.
- R7: `vic_way` is the lowest-index invalid entry if one exists; otherwise it is the entry at depth N-1. `vic_valid` is 1 only when the victim holds a valid line.
- R8: A taken insert writes the block-aligned `ins_addr` into the victim, marks it valid and moves it to depth 0, with the same shifting as R3.
- R9: A taken invalidate clears the valid bit of `inv_way` and leaves every depth unchanged. That entry can no longer hit.
- R10: If several strobes are raised in one cycle, only one operation is taken. Invalidate wins over access, and access wins over insert. The operations that lose are ignored, including their counter updates.
- R11: After reset, all entries are invalid, entry i sits at depth i and all counters are zero. Consecutive inserts therefore fill ways 0, 1, 2, … in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe (updates recency on hit) |
| acc_addr | input | ADDR_W | Access address |
| acc_hit | output | 1 | Access matches a valid entry |
| acc_way | output | IDX_W | Matching way of the access |
| acc_mask | output | NUM_SIZES | Per-size residency of the access |
| prb_addr | input | ADDR_W | Probe address (no side effects) |
| prb_hit | output | 1 | Probe matches a valid entry |
| prb_way | output | IDX_W | Matching way of the probe |
| vic_way | output | IDX_W | Replacement candidate |
| vic_valid | output | 1 | Candidate currently holds a valid line |
| vic_addr | output | ADDR_W | Block address held by the candidate |
| ins_valid | input | 1 | Insert strobe |
| ins_addr | input | ADDR_W | Address to install into the candidate |
| inv_valid | input | 1 | Invalidate strobe |
| inv_way | input | IDX_W | Way to invalidate |
| cnt_access | output | CNT_W | Taken access count |
| cnt_hit | output | LVLS·CNT_W | Hit count per size level |
| cnt_miss | output | LVLS·CNT_W | Miss count per size level |

## Verification
The assertions assume the issuer never inserts an address that already sits in a valid entry, so the tag store never holds duplicates. They also assume that `inv_way` is below N. The stimulus meets the first condition by inserting only after an access or probe to that address has missed. It meets the second by drawing invalidation targets from the way range. Within these limits the depths stay a permutation of 0..N-1, and the checker verifies that property on every cycle.

// File: rtl/mlru_pkg.sv
package mlru_pkg;
  // Operation selected for the current cycle after priority resolution
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_INV  = 2'd1,
    OP_ACC  = 2'd2,
    OP_INS  = 2'd3
  } mlru_op_e;
endpackage

// File: rtl/mlru_tag_array.sv
module mlru_tag_array #(
  parameter int N     = 16,
  parameter int TAG_W = 26,
  parameter int IDX_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TAG_W-1:0]           acc_tag,
  input  logic [TAG_W-1:0]           prb_tag,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       clr_en,
  input  logic [IDX_W-1:0]           clr_idx,
  output logic [N-1:0]               valid_o,
  output logic [N-1:0][TAG_W-1:0]    tags_o,
  output logic [N-1:0]               acc_match,
  output logic [N-1:0]               prb_match
);
  logic [N-1:0]            valid_q;
  logic [N-1:0][TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else begin
      if (clr_en) valid_q[clr_idx] <= 1'b0;
      if (wr_en) begin
        valid_q[wr_idx] <= 1'b1;
        tag_q[wr_idx]   <= wr_tag;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign acc_match[g] = valid_q[g] && (tag_q[g] == acc_tag);
    assign prb_match[g] = valid_q[g] && (tag_q[g] == prb_tag);
  end

  assign valid_o = valid_q;
  assign tags_o  = tag_q;
endmodule

// File: rtl/mlru_stack.sv
module mlru_stack #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic [IDX_W-1:0]        upd_idx,
  output logic [N-1:0][IDX_W-1:0] pos_o
);
  logic [N-1:0][IDX_W-1:0] pos_q;
  logic [IDX_W-1:0]        old_pos;

  assign old_pos = pos_q[upd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) pos_q[i] <= IDX_W'(i);
    end else if (upd_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == upd_idx)  pos_q[i] <= '0;
        else if (pos_q[i] < old_pos) pos_q[i] <= pos_q[i] + 1'b1;
      end
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/mlru_victim.sv
module mlru_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]               valid,
  input  logic [N-1:0][IDX_W-1:0]    pos,
  output logic [IDX_W-1:0]           vic_idx,
  output logic                       vic_occupied
);
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] lru_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pos[i] == IDX_W'(N - 1)) lru_idx = IDX_W'(i);
    end
  end

  assign vic_idx      = any_free ? free_idx : lru_idx;
  assign vic_occupied = !any_free;
endmodule

// File: rtl/mlru_stats.sv
module mlru_stats #(
  parameter int LVLS  = 4,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [LVLS-1:0]            resident,
  output logic [CNT_W-1:0]           acc_cnt,
  output logic [LVLS-1:0][CNT_W-1:0] hit_cnt,
  output logic [LVLS-1:0][CNT_W-1:0] miss_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) acc_cnt <= '0;
    else if (en) acc_cnt <= acc_cnt + 1'b1;
  end

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hit_cnt[g]  <= '0;
        miss_cnt[g] <= '0;
      end else if (en) begin
        if (resident[g]) hit_cnt[g]  <= hit_cnt[g] + 1'b1;
        else             miss_cnt[g] <= miss_cnt[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mlru_tag_store.sv
module mlru_tag_store
  import mlru_pkg::*;
#(
  parameter int N_ENTRIES    = 16,
  parameter int ADDR_W       = 32,
  parameter int BLK_BYTES    = 64,
  parameter int BASE_ENTRIES = 2,
  parameter int CNT_W        = 16,
  localparam int IDX_W       = $clog2(N_ENTRIES),
  localparam int NUM_SIZES   = $clog2(N_ENTRIES / BASE_ENTRIES),
  localparam int LVLS        = NUM_SIZES + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [ADDR_W-1:0]       acc_addr,
  output logic                    acc_hit,
  output logic [IDX_W-1:0]        acc_way,
  output logic [NUM_SIZES-1:0]    acc_mask,
  input  logic [ADDR_W-1:0]       prb_addr,
  output logic                    prb_hit,
  output logic [IDX_W-1:0]        prb_way,
  output logic [IDX_W-1:0]        vic_way,
  output logic                    vic_valid,
  output logic [ADDR_W-1:0]       vic_addr,
  input  logic                    ins_valid,
  input  logic [ADDR_W-1:0]       ins_addr,
  input  logic                    inv_valid,
  input  logic [IDX_W-1:0]        inv_way,
  output logic [CNT_W-1:0]        cnt_access,
  output logic [LVLS*CNT_W-1:0]   cnt_hit,
  output logic [LVLS*CNT_W-1:0]   cnt_miss
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  mlru_op_e                    op;
  logic [N_ENTRIES-1:0]        ent_valid;
  logic [N_ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [N_ENTRIES-1:0][IDX_W-1:0] ent_pos;
  logic [N_ENTRIES-1:0]        acc_match;
  logic [N_ENTRIES-1:0]        prb_match;
  logic [IDX_W-1:0]            acc_depth;
  logic [LVLS-1:0]             lvl_res;
  logic                        stk_en;
  logic [IDX_W-1:0]            stk_idx;
  logic [LVLS-1:0][CNT_W-1:0]  hit_cnt;
  logic [LVLS-1:0][CNT_W-1:0]  miss_cnt;

  // Priority: invalidate, then access, then insert
  always_comb begin
    if (inv_valid)      op = OP_INV;
    else if (acc_valid) op = OP_ACC;
    else if (ins_valid) op = OP_INS;
    else                op = OP_IDLE;
  end

  mlru_tag_array #(.N(N_ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_tag   (acc_addr[ADDR_W-1:OFF_W]),
    .prb_tag   (prb_addr[ADDR_W-1:OFF_W]),
    .wr_en     (op == OP_INS),
    .wr_idx    (vic_way),
    .wr_tag    (ins_addr[ADDR_W-1:OFF_W]),
    .clr_en    (op == OP_INV),
    .clr_idx   (inv_way),
    .valid_o   (ent_valid),
    .tags_o    (ent_tag),
    .acc_match (acc_match),
    .prb_match (prb_match)
  );

  // One-hot match vectors to way indices
  always_comb begin
    acc_way = '0;
    prb_way = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (acc_match[i]) acc_way = acc_way | IDX_W'(i);
      if (prb_match[i]) prb_way = prb_way | IDX_W'(i);
    end
  end

  assign acc_hit   = |acc_match;
  assign prb_hit   = |prb_match;
  assign acc_depth = ent_pos[acc_way];

  // A line is resident in a size-C cache exactly when its depth is below C
  for (genvar g = 0; g < LVLS; g++) begin : g_res
    localparam int CAP = BASE_ENTRIES << g;
    assign lvl_res[g] = acc_hit && ({1'b0, acc_depth} < (IDX_W + 1)'(CAP));
  end
  assign acc_mask = lvl_res[NUM_SIZES-1:0];

  mlru_victim #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid        (ent_valid),
    .pos          (ent_pos),
    .vic_idx      (vic_way),
    .vic_occupied (vic_valid)
  );
  assign vic_addr = {ent_tag[vic_way], {OFF_W{1'b0}}};

  assign stk_en  = (op == OP_INS) || ((op == OP_ACC) && acc_hit);
  assign stk_idx = (op == OP_INS) ? vic_way : acc_way;

  mlru_stack #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (stk_en),
    .upd_idx (stk_idx),
    .pos_o   (ent_pos)
  );

  mlru_stats #(.LVLS(LVLS), .CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (op == OP_ACC),
    .resident (lvl_res),
    .acc_cnt  (cnt_access),
    .hit_cnt  (hit_cnt),
    .miss_cnt (miss_cnt)
  );
  assign cnt_hit  = hit_cnt;
  assign cnt_miss = miss_cnt;
endmodule

// File: rtl/mlru_tag_store_chk.sv
module mlru_tag_store_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4,
  parameter int NS    = 3,
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_valid,
  input logic                    ins_valid,
  input logic                    inv_valid,
  input logic [IDX_W-1:0]        inv_way,
  input logic                    acc_hit,
  input logic [IDX_W-1:0]        acc_way,
  input logic [NS-1:0]           acc_mask,
  input logic                    vic_valid,
  input logic [N-1:0]            ent_valid,
  input logic [N-1:0][IDX_W-1:0] ent_pos,
  input logic [CNT_W-1:0]        cnt_access
);
  logic [IDX_W-1:0] last_acc_way;
  logic [IDX_W-1:0] last_inv_way;
  logic [N-1:0]     depth_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_acc_way <= '0;
      last_inv_way <= '0;
    end else begin
      last_acc_way <= acc_way;
      last_inv_way <= inv_way;
    end
  end

  always_comb begin
    depth_seen = '0;
    for (int i = 0; i < N; i++) depth_seen[ent_pos[i]] = 1'b1;
  end

  // R3: a taken hit lands at depth 0
  a_r3_hit_to_mru: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !inv_valid && acc_hit) |=> (ent_pos[last_acc_way] == '0));

  // R4: cycles with no strobe (probe only) leave the state alone
  a_r4_probe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !ins_valid && !inv_valid) |=> ($stable(ent_pos) && $stable(ent_valid)));

  // R5: mask is nested (smaller size resident implies larger) and needs a hit
  a_r5_mask_nested: assert property (@(posedge clk) disable iff (!rst_n)
    (((acc_mask << 1) & ~acc_mask) == '0) && ((acc_mask == '0) || acc_hit));

  // R6: each taken access adds one to the total
  a_r6_access_count: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !inv_valid) |=> (cnt_access == CNT_W'($past(cnt_access) + 1'b1)));

  // R7: a free entry is preferred over evicting a valid line
  a_r7_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ent_valid)) |-> !vic_valid);

  // R9: invalidated way is no longer valid
  a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !ent_valid[last_inv_way]);

  // R11: depths always form a permutation of 0..N-1
  a_r11_depth_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (&depth_seen));
endmodule

bind mlru_tag_store mlru_tag_store_chk #(
  .N(N_ENTRIES), .IDX_W(IDX_W), .NS(NUM_SIZES), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .ins_valid  (ins_valid),
  .inv_valid  (inv_valid),
  .inv_way    (inv_way),
  .acc_hit    (acc_hit),
  .acc_way    (acc_way),
  .acc_mask   (acc_mask),
  .vic_valid  (vic_valid),
  .ent_valid  (ent_valid),
  .ent_pos    (ent_pos),
  .cnt_access (cnt_access)
);

// File: tb/mlru_tag_store_bench.sv
module mlru_tag_store_bench;
  localparam int N     = 16;
  localparam int AW    = 32;
  localparam int OFF   = 6;
  localparam int BASE  = 2;
  localparam int CW    = 16;
  localparam int IW    = 4;
  localparam int NS    = 3;
  localparam int LV    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, ins_valid = 1'b0, inv_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0, prb_addr = '0, ins_addr = '0;
  logic [IW-1:0] inv_way = '0;
  logic acc_hit, prb_hit, vic_valid;
  logic [IW-1:0] acc_way, prb_way, vic_way;
  logic [NS-1:0] acc_mask;
  logic [AW-1:0] vic_addr;
  logic [CW-1:0] cnt_access;
  logic [LV*CW-1:0] cnt_hit, cnt_miss;

  always #5 clk = ~clk;

  mlru_tag_store u_mlru_tag_store (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_hit(acc_hit),
    .acc_way(acc_way), .acc_mask(acc_mask),
    .prb_addr(prb_addr), .prb_hit(prb_hit), .prb_way(prb_way),
    .vic_way(vic_way), .vic_valid(vic_valid), .vic_addr(vic_addr),
    .ins_valid(ins_valid), .ins_addr(ins_addr),
    .inv_valid(inv_valid), .inv_way(inv_way),
    .cnt_access(cnt_access), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference model: block address per way, validity, recency list (index 0 = MRU)
  logic [AW-1:0] m_tag [N];
  bit            m_val [N];
  int            m_ord [N];
  int            e_acc;
  int            e_hit [LV];
  int            e_miss[LV];
  logic [31:0]   seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [AW-1:0] blk(input logic [AW-1:0] a);
    return {a[AW-1:OFF], {OFF{1'b0}}};
  endfunction

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == blk(a)) return i;
    return -1;
  endfunction

  function automatic int m_depth(input int w);
    for (int k = 0; k < N; k++) if (m_ord[k] == w) return k;
    return -1;
  endfunction

  function automatic void m_promote(input int w);
    int d;
    d = m_depth(w);
    for (int k = d; k > 0; k--) m_ord[k] = m_ord[k-1];
    m_ord[0] = w;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    return m_ord[N-1];
  endfunction

  task automatic do_access(input logic [AW-1:0] a, output bit hit);
    int w, d;
    logic [NS-1:0] em;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a;
    #2;
    w = m_find(a);
    hit = (w >= 0);
    d = hit ? m_depth(w) : N;
    chk(acc_hit == hit, "R2 hit", acc_hit, hit);
    if (hit) chk(acc_way == IW'(w), "R2/R1 way", acc_way, w);
    em = '0;
    for (int i = 0; i < NS; i++) em[i] = hit && (d < (BASE << i));
    chk(acc_mask == em, "R5 mask", acc_mask, em);
    @(posedge clk);
    e_acc++;
    for (int i = 0; i < LV; i++)
      if (hit && d < (BASE << i)) e_hit[i]++; else e_miss[i]++;
    if (hit) m_promote(w);
    #1 acc_valid = 1'b0;
  endtask

  task automatic do_insert(input logic [AW-1:0] a);
    int v;
    @(negedge clk);
    v = m_victim();
    #2;
    chk(vic_way == IW'(v), "R7 victim way", vic_way, v);
    chk(vic_valid == m_val[v], "R7 victim valid", vic_valid, m_val[v]);
    chk(vic_addr[OFF-1:0] == '0, "R1 victim offset", vic_addr[OFF-1:0], 0);
    if (m_val[v]) chk(vic_addr == m_tag[v], "R1 victim addr", vic_addr, m_tag[v]);
    ins_valid = 1'b1; ins_addr = a;
    @(posedge clk);
    m_tag[v] = blk(a); m_val[v] = 1'b1; m_promote(v);
    #1 ins_valid = 1'b0;
  endtask

  task automatic do_inv(input int w);
    @(negedge clk);
    inv_valid = 1'b1; inv_way = IW'(w);
    @(posedge clk);
    m_val[w] = 1'b0;
    #1 inv_valid = 1'b0;
  endtask

  task automatic do_probe(input logic [AW-1:0] a, output bit hit);
    int w;
    @(negedge clk);
    prb_addr = a;
    #2;
    w = m_find(a);
    hit = (w >= 0);
    chk(prb_hit == hit, "R4 probe hit", prb_hit, hit);
    if (hit) chk(prb_way == IW'(w), "R4 probe way", prb_way, w);
  endtask

  task automatic chk_counters(input string req);
    @(negedge clk);
    chk(cnt_access == CW'(e_acc), {req, " access count"}, cnt_access, e_acc);
    for (int i = 0; i < LV; i++) begin
      chk(cnt_hit[i*CW +: CW] == CW'(e_hit[i]), {req, " hit count"}, cnt_hit[i*CW +: CW], e_hit[i]);
      chk(cnt_miss[i*CW +: CW] == CW'(e_miss[i]), {req, " miss count"}, cnt_miss[i*CW +: CW], e_miss[i]);
    end
  endtask

  function automatic logic [AW-1:0] pool_addr(input int k);
    return AW'((k + 1) << 12) | AW'(rnd() & 32'h3f);
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit h;
    int w, a;
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_tag[i] = '0; m_ord[i] = i; end
    e_acc = 0;
    for (int i = 0; i < LV; i++) begin e_hit[i] = 0; e_miss[i] = 0; end

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset state
    @(negedge clk);
    #2;
    chk(vic_way == '0, "R11 reset victim", vic_way, 0);
    chk(vic_valid == 1'b0, "R11 reset victim valid", vic_valid, 0);
    chk(prb_hit == 1'b0, "R11 reset no hit", prb_hit, 0);
    chk_counters("R11 reset");
    do_access(32'h0, h);   // R2: miss on empty store

    // R11/R8: fill in way order, offsets non-zero
    for (int i = 0; i < N; i++) do_insert(AW'(((i + 1) << 12) | (i + 3)));

    // R1/R3/R5: revisit oldest-first with other offsets (each at the LRU end)
    for (int i = 0; i < N; i++) do_access(AW'(((i + 1) << 12) | 6'h3f), h);
    chk_counters("R6 fill");

    // R4: probes between accesses must not move anything
    for (int i = 0; i < 8; i++) begin
      do_probe(AW'((i + 1) << 12), h);
      do_access(AW'(((16 - i) << 12)), h);
    end

    // Mixed sweep over a pool larger than the store
    for (int n = 0; n < 3000; n++) begin
      a = int'(rnd() % 24);
      case (rnd() % 16)
        0, 1, 2, 3, 4, 5, 6, 7, 8: begin
          do_access(pool_addr(a), h);
          if (!h) do_insert(pool_addr(a));   // R8
        end
        9, 10, 11: begin
          do_probe(pool_addr(a), h);
          if (!h) do_insert(pool_addr(a));
        end
        12: do_inv(int'(rnd() % N));          // R9
        default: begin @(negedge clk); end
      endcase
      if (n % 500 == 0) chk_counters("R6 sweep");
    end

    // R9: invalidate a resident line, then it cannot hit and is the victim
    w = m_find(pool_addr(1));
    if (w < 0) begin do_insert(pool_addr(1)); w = m_find(pool_addr(1)); end
    do_inv(w);
    do_access(pool_addr(1), h);
    chk(h == 0, "R9 invalidated misses", h, 0);
    do_insert(pool_addr(1));

    // R10: invalidate beats access in the same cycle
    w = m_find(pool_addr(1));
    @(negedge clk);
    inv_valid = 1'b1; inv_way = IW'(m_ord[N-1]); acc_valid = 1'b1; acc_addr = pool_addr(1);
    @(posedge clk);
    m_val[m_ord[N-1]] = 1'b0;
    #1 inv_valid = 1'b0; acc_valid = 1'b0;
    chk_counters("R10 inv over access");
    do_access(pool_addr(1), h);   // depth must be unchanged by the ignored access

    // R10: access beats insert in the same cycle
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = pool_addr(1); ins_valid = 1'b1; ins_addr = 32'h00ff_0000;
    @(posedge clk);
    e_acc++;
    w = m_find(pool_addr(1));
    for (int i = 0; i < LV; i++)
      if (w >= 0 && m_depth(w) < (BASE << i)) e_hit[i]++; else e_miss[i]++;
    if (w >= 0) m_promote(w);
    #1 acc_valid = 1'b0; ins_valid = 1'b0;
    do_probe(32'h00ff_0000, h);
    chk(h == 0, "R10 insert ignored", h, 0);

    // R7: with no free way, the LRU line is evicted
    for (int i = 0; i < N; i++) if (!m_val[i]) do_insert(AW'((i + 64) << 12));
    do_insert(32'h0abc_0000);
    chk_counters("R6 final");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule